// File: doc/BRIEF.md
# Indirect Byte-Register Bridge

This block lets a processor on a 32-bit memory-mapped bus reach an 8-bit register space inside a slow subsystem. It does not map the subsystem registers directly. Software instead programs a command word that holds the subsystem address, a transfer direction and byte-lane enables. It then moves data through a pair of 32-bit data registers and polls a busy flag until the subsystem has answered.

A write transfer is launched by the store to the lower data register once a command with direction 0 is in place. A read transfer is launched by the store of a command word with the direction bit set. The returned byte lands in the lower data register when busy drops. Towards the subsystem the bridge drives a request that is held until a one-cycle acknowledge. Address, direction and write byte stay steady for the whole request.

An interrupt enable register and a write-one-to-clear flag register gather two events: a level interrupt from the subsystem and the completion of a transfer. Their enabled OR drives a single interrupt line.

Top module: `ibr_bridge`

## Requirements
- R1: The word at byte offset 0x00 reads the constant given by parameter ID_VALUE. Offsets 0x18 and 0x1C, and misaligned offsets, read 0.
- R2: The command register at offset 0x04 reads back with this layout: bit 31 busy (read only), bit 25 size, bit 24 direction (1 = read), bits 23:20 upper lane enables, bits 19:16 lower lane enables, and bits SUB_ADDR_W-1:0 the subsystem address. All other bits read 0. Storing a command with direction 0 starts nothing.
- R3: When idle and the stored direction is 0, a store to the lower data register at offset 0x08 keeps the value and starts a write. From the next cycle busy reads 1 and sub_req, sub_we are 1. sub_addr equals the command address. sub_wdata is the byte of lower data in the lowest lane whose lower enable is set, where lane k is bits 8k+7:8k; lane 0 is used when no enable is set.
- R4: When idle, a command store with bit 24 set starts a read from the next cycle, with sub_req 1 and sub_we 0. A store to lower data while the stored direction is 1 only keeps the value and starts nothing.
- R5: A cycle with sub_ack high while busy ends the transfer, and busy reads 0 after that edge. For a read, lower data becomes sub_rdata placed in the lane chosen as in R3, with every other lane 0.
- R6: sub_req, sub_addr, sub_we and sub_wdata hold steady from the start of a transfer until its acknowledge. sub_ack while idle changes no state.
- R7: While busy, stores to the command, lower data and upper data registers are ignored.
- R8: The upper data register at offset 0x0C is plain 32-bit read/write storage.
- R9: The enable register at 0x10 and the flag register at 0x14 use bit 1 for the subsystem interrupt and bit 0 for transfer completion. A flag bit is set in every cycle its event is present: sub_irq high for bit 1, an acknowledged transfer for bit 0. Writing 1 clears a flag bit, and a set in the same cycle wins over the clear.
- R10: irq_o is high exactly when some flag bit and the matching enable bit are both 1.
- R11: After reset, the command, both data registers, the enables and the flags read 0, and sub_req and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe for the current address |
| bus_addr | input | BUS_ADDR_W | Byte offset of the bridge register |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sub_req | output | 1 | Transfer request to the subsystem |
| sub_we | output | 1 | 1 = write transfer, 0 = read transfer |
| sub_addr | output | SUB_ADDR_W | Subsystem register address |
| sub_wdata | output | 8 | Byte to be written |
| sub_ack | input | 1 | One-cycle acknowledge from the subsystem |
| sub_rdata | input | 8 | Byte returned with the acknowledge of a read |
| sub_irq | input | 1 | Level interrupt from the subsystem |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
The hardest state to reach from the ports is a transfer that stays outstanding long enough for software to hit the bridge while busy. In normal use the subsystem answers within a few cycles and the busy window closes before the next store. The bench subsystem model therefore has a stall control that withholds the acknowledge. That leaves room to store to the command and data registers during a live request, and to check that readback and the request fields stay unchanged. The same model can inject an acknowledge with no request pending. Random transfers with random lane enables and random acknowledge latency then cover the lane selection in both directions.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_LDATA = 8'h08;
  localparam logic [7:0] OFS_UDATA = 8'h0C;
  localparam logic [7:0] OFS_IEN   = 8'h10;
  localparam logic [7:0] OFS_IFLG  = 8'h14;

  // command word fields
  localparam int CMD_BUSY_BIT = 31;
  localparam int CMD_SIZE_BIT = 25;
  localparam int CMD_DIR_BIT  = 24;
  localparam int CMD_UEN_LSB  = 20;
  localparam int CMD_LEN_LSB  = 16;
  localparam int LANES        = 4;
  localparam int LANE_W       = 8;

  // interrupt sources
  localparam int EVT_XFER = 0;
  localparam int EVT_SUB  = 1;
  localparam int EVT_N    = 2;

  typedef enum logic [2:0] {
    SEL_ID, SEL_CMD, SEL_LDATA, SEL_UDATA, SEL_IEN, SEL_IFLG, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/ibr_lane_sel.sv
module ibr_lane_sel #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        en_i,
  input  logic [LANES*LANE_W-1:0] word_i,
  input  logic [LANE_W-1:0]       byte_i,
  output logic [LANE_W-1:0]       byte_o,
  output logic [LANES*LANE_W-1:0] word_o
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0] idx;

  // lowest enabled lane wins, lane 0 when none enabled
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (en_i[i]) idx = IDX_W'(i);
    end
  end

  assign byte_o = word_i[idx*LANE_W +: LANE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[g*LANE_W +: LANE_W] = (idx == IDX_W'(g)) ? byte_i : '0;
  end
endmodule

// File: rtl/ibr_xfer_ctl.sv
module ibr_xfer_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, busy_d;

  always_comb begin
    if (busy_q) busy_d = ~ack_i;
    else        busy_d = start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;
  assign done_o = busy_q & ack_i;
endmodule

// File: rtl/ibr_irq_ctl.sv
module ibr_irq_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic         flg_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] flg_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, en_d, flg_q, flg_d, clr;

  always_comb begin
    clr   = flg_we ? wdata : '0;
    flg_d = (flg_q & ~clr) | evt_i;
    en_d  = en_q;
    if (en_we) en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      en_q  <= en_d;
      flg_q <= flg_d;
    end
  end

  assign en_o  = en_q;
  assign flg_o = flg_q;
  assign irq_o = |(en_q & flg_q);
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
  parameter int          BUS_ADDR_W = 5,
  parameter int          SUB_ADDR_W = 8,
  parameter logic [31:0] ID_VALUE   = 32'h1B5E_0001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  sub_req,
  output logic                  sub_we,
  output logic [SUB_ADDR_W-1:0] sub_addr,
  output logic [7:0]            sub_wdata,
  input  logic                  sub_ack,
  input  logic [7:0]            sub_rdata,
  input  logic                  sub_irq,
  output logic                  irq_o
);
  import ibr_pkg::*;

  localparam int WORD_W = LANES * LANE_W;
  localparam logic [BUS_ADDR_W-1:0] A_ID    = BUS_ADDR_W'(OFS_ID);
  localparam logic [BUS_ADDR_W-1:0] A_CMD   = BUS_ADDR_W'(OFS_CMD);
  localparam logic [BUS_ADDR_W-1:0] A_LDATA = BUS_ADDR_W'(OFS_LDATA);
  localparam logic [BUS_ADDR_W-1:0] A_UDATA = BUS_ADDR_W'(OFS_UDATA);
  localparam logic [BUS_ADDR_W-1:0] A_IEN   = BUS_ADDR_W'(OFS_IEN);
  localparam logic [BUS_ADDR_W-1:0] A_IFLG  = BUS_ADDR_W'(OFS_IFLG);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // address decode
  reg_sel_e sel;
  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == A_ID)    sel = SEL_ID;
    else if (bus_addr == A_CMD)   sel = SEL_CMD;
    else if (bus_addr == A_LDATA) sel = SEL_LDATA;
    else if (bus_addr == A_UDATA) sel = SEL_UDATA;
    else if (bus_addr == A_IEN)   sel = SEL_IEN;
    else if (bus_addr == A_IFLG)  sel = SEL_IFLG;
  end

  logic busy, done;

  // write strobes; data path registers are frozen while busy
  logic cmd_we, ldata_we, udata_we, ien_we, iflg_we;
  always_comb begin
    cmd_we   = bus_we & (sel == SEL_CMD)   & ~busy;
    ldata_we = bus_we & (sel == SEL_LDATA) & ~busy;
    udata_we = bus_we & (sel == SEL_UDATA) & ~busy;
    ien_we   = bus_we & (sel == SEL_IEN);
    iflg_we  = bus_we & (sel == SEL_IFLG);
  end

  // command register
  logic                  cmd_size_q, cmd_dir_q;
  logic [LANES-1:0]      cmd_uen_q, cmd_len_q;
  logic [SUB_ADDR_W-1:0] cmd_addr_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_size_q <= 1'b0;
      cmd_dir_q  <= 1'b0;
      cmd_uen_q  <= '0;
      cmd_len_q  <= '0;
      cmd_addr_q <= '0;
    end else if (cmd_we) begin
      cmd_size_q <= bus_wdata[CMD_SIZE_BIT];
      cmd_dir_q  <= bus_wdata[CMD_DIR_BIT];
      cmd_uen_q  <= bus_wdata[CMD_UEN_LSB +: LANES];
      cmd_len_q  <= bus_wdata[CMD_LEN_LSB +: LANES];
      cmd_addr_q <= bus_wdata[SUB_ADDR_W-1:0];
    end
  end

  // lane selection shared by both directions
  logic [LANE_W-1:0] lane_byte;
  logic [WORD_W-1:0] rd_word;

  ibr_lane_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
    .en_i   (cmd_len_q),
    .word_i (ldata_q),
    .byte_i (sub_rdata),
    .byte_o (lane_byte),
    .word_o (rd_word)
  );

  // data registers
  logic [WORD_W-1:0] ldata_q, ldata_d, udata_q;
  logic              ldata_en;

  always_comb begin
    ldata_en = ldata_we | (done & cmd_dir_q);
    ldata_d  = ldata_we ? bus_wdata : rd_word;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   ldata_q <= '0;
    else if (ldata_en) ldata_q <= ldata_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   udata_q <= '0;
    else if (udata_we) udata_q <= bus_wdata;
  end

  // transfer sequencing
  logic start;
  assign start = (cmd_we & bus_wdata[CMD_DIR_BIT]) | (ldata_we & ~cmd_dir_q);

  ibr_xfer_ctl u_xfer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .ack_i   (sub_ack),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign sub_req   = busy;
  assign sub_we    = ~cmd_dir_q;
  assign sub_addr  = cmd_addr_q;
  assign sub_wdata = lane_byte;

  // interrupts
  logic [EVT_N-1:0] evt, ien_w, iflg_w;
  always_comb begin
    evt           = '0;
    evt[EVT_XFER] = done;
    evt[EVT_SUB]  = sub_irq;
  end

  ibr_irq_ctl #(.N(EVT_N)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_we  (ien_we),
    .flg_we (iflg_we),
    .wdata  (bus_wdata[EVT_N-1:0]),
    .evt_i  (evt),
    .en_o   (ien_w),
    .flg_o  (iflg_w),
    .irq_o  (irq_o)
  );

  // read mux
  logic [31:0] cmd_word;
  always_comb begin
    cmd_word                          = '0;
    cmd_word[CMD_BUSY_BIT]            = busy;
    cmd_word[CMD_SIZE_BIT]            = cmd_size_q;
    cmd_word[CMD_DIR_BIT]             = cmd_dir_q;
    cmd_word[CMD_UEN_LSB +: LANES]    = cmd_uen_q;
    cmd_word[CMD_LEN_LSB +: LANES]    = cmd_len_q;
    cmd_word[SUB_ADDR_W-1:0]          = cmd_addr_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_ID:    bus_rdata = ID_VALUE;
      SEL_CMD:   bus_rdata = cmd_word;
      SEL_LDATA: bus_rdata = ldata_q;
      SEL_UDATA: bus_rdata = udata_q;
      SEL_IEN:   bus_rdata[EVT_N-1:0] = ien_w;
      SEL_IFLG:  bus_rdata[EVT_N-1:0] = iflg_w;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int BUS_ADDR_W = 5,
  parameter int SUB_ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic                  bus_we,
  input logic [BUS_ADDR_W-1:0] bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  sub_req,
  input logic                  sub_we,
  input logic [SUB_ADDR_W-1:0] sub_addr,
  input logic [7:0]            sub_wdata,
  input logic                  sub_ack,
  input logic                  sub_irq,
  input logic                  irq_o,
  input logic [1:0]            ien,
  input logic [1:0]            iflg
);
  localparam logic [BUS_ADDR_W-1:0] A_CMD = BUS_ADDR_W'(8'h04);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_req && !sub_ack |=> sub_req);

  p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_req && !sub_ack |=> $stable(sub_addr) && $stable(sub_we) && $stable(sub_wdata));

  p_idle_ack_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !sub_req && !bus_we |=> !sub_req);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_req && sub_ack |=> !sub_req);

  p_read_start_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    !sub_req && bus_we && (bus_addr == A_CMD) && bus_wdata[24] |=> sub_req && !sub_we);

  p_sub_flag_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_irq |=> iflg[1]);

  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_req && sub_ack |=> iflg[0]);

  p_irq_raise_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_irq && ien[1] && !bus_we |=> irq_o);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (iflg == 2'b00) |-> !irq_o);
endmodule

bind ibr_bridge ibr_bridge_chk #(.BUS_ADDR_W(BUS_ADDR_W), .SUB_ADDR_W(SUB_ADDR_W)) chk_i (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sub_req   (sub_req),
  .sub_we    (sub_we),
  .sub_addr  (sub_addr),
  .sub_wdata (sub_wdata),
  .sub_ack   (sub_ack),
  .sub_irq   (sub_irq),
  .irq_o     (irq_o),
  .ien       (ien_w),
  .iflg      (iflg_w)
);

// File: tb/ibr_bridge_tb_top.sv
`timescale 1ns/1ps
module ibr_bridge_tb_top;
  localparam logic [31:0] ID_K = 32'h1B5E_0001;
  localparam logic [4:0] O_ID = 5'h00, O_CMD = 5'h04, O_LD = 5'h08, O_UD = 5'h0C,
                         O_IEN = 5'h10, O_IFL = 5'h14;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_we;
  logic [4:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic sub_req, sub_we, sub_ack, sub_irq, irq_o;
  logic [7:0] sub_addr, sub_wdata, sub_rdata;

  always #4 clk = ~clk;

  ibr_bridge #(.BUS_ADDR_W(5), .SUB_ADDR_W(8), .ID_VALUE(ID_K)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_req(sub_req),
    .sub_we(sub_we), .sub_addr(sub_addr), .sub_wdata(sub_wdata),
    .sub_ack(sub_ack), .sub_rdata(sub_rdata), .sub_irq(sub_irq), .irq_o(irq_o));

  int n_chk = 0;
  int n_bad = 0;
  logic stall = 1'b0;
  logic idle_ack = 1'b0;
  logic [7:0] mem [256];
  int unsigned ack_cnt;

  // subsystem model: acknowledges after a random delay unless stalled
  initial begin
    sub_ack = 1'b0;
    sub_rdata = 8'h00;
    ack_cnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    forever begin
      @(negedge clk);
      if (sub_ack) sub_ack = 1'b0;
      else if (idle_ack) sub_ack = 1'b1;
      else if (sub_req && !stall) begin
        if (ack_cnt == 0) begin
          sub_ack = 1'b1;
          sub_rdata = mem[sub_addr];
          if (sub_we) mem[sub_addr] = sub_wdata;
          ack_cnt = $urandom_range(0, 3);
        end else ack_cnt = ack_cnt - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 100; k++) begin
      rd(O_CMD, v);
      if (!v[31]) break;
      @(negedge clk);
    end
  endtask

  function automatic int lane_of(input logic [3:0] en);
    for (int i = 0; i < 4; i++) if (en[i]) return i;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic [31:0] v, d;
    logic [7:0] a;
    logic [3:0] en;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; sub_irq = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    rd(O_CMD, v); chk("R11 cmd", v, 0);
    rd(O_LD, v);  chk("R11 ldata", v, 0);
    rd(O_UD, v);  chk("R11 udata", v, 0);
    rd(O_IEN, v); chk("R11 ien", v, 0);
    rd(O_IFL, v); chk("R11 iflg", v, 0);
    chk("R11 req/irq", {30'b0, sub_req, irq_o}, 0);

    // R1 identification and holes
    rd(O_ID, v);  chk("R1 id", v, ID_K);
    rd(5'h18, v); chk("R1 hole 0x18", v, 0);
    rd(5'h05, v); chk("R1 misaligned", v, 0);

    // R2 field layout, direction 0 starts nothing
    wr(O_CMD, 32'hFEFF_FFFF);
    rd(O_CMD, v); chk("R2 layout", v, 32'h02FF_00FF);
    chk("R2 no start", {31'b0, sub_req}, 0);

    // R8 upper data storage
    wr(O_UD, 32'hCAFE_F00D);
    rd(O_UD, v); chk("R8 udata", v, 32'hCAFE_F00D);

    // R3 write start with lane 2, held by stall
    stall = 1'b1;
    wr(O_CMD, 32'h0004_003C);
    wr(O_LD, 32'hA1B2_C3D4);
    rd(O_CMD, v); chk("R3 busy", v, 32'h8004_003C);
    chk("R3 req/we", {30'b0, sub_req, sub_we}, 3);
    chk("R3 addr", {24'b0, sub_addr}, 32'h3C);
    chk("R3 wbyte lane2", {24'b0, sub_wdata}, 32'hB2);

    // R7 stores while busy ignored
    wr(O_CMD, 32'h0100_0011);
    wr(O_LD, 32'h0);
    wr(O_UD, 32'h1234);
    rd(O_CMD, v); chk("R7 cmd kept", v, 32'h8004_003C);
    rd(O_LD, v);  chk("R7 ldata kept", v, 32'hA1B2_C3D4);
    rd(O_UD, v);  chk("R7 udata kept", v, 32'hCAFE_F00D);
    chk("R6 addr held", {24'b0, sub_addr}, 32'h3C);
    stall = 1'b0;
    wait_idle();
    chk("R3 byte written", {24'b0, mem[8'h3C]}, 32'hB2);
    rd(O_IFL, v); chk("R9 done flag", v, 1);
    chk("R10 masked", {31'b0, irq_o}, 0);
    wr(O_IEN, 1);
    chk("R10 enabled", {31'b0, irq_o}, 1);
    wr(O_IFL, 1);
    rd(O_IFL, v); chk("R9 w1c", v, 0);
    chk("R10 cleared", {31'b0, irq_o}, 0);
    wr(O_IEN, 0);

    // R3 no lane enable -> lane 0
    stall = 1'b1;
    wr(O_CMD, 32'h0000_0021);
    wr(O_LD, 32'h1122_3344);
    chk("R3 wbyte lane0", {24'b0, sub_wdata}, 32'h44);
    stall = 1'b0;
    wait_idle();

    // R5 read into lane 3, R4 read start
    stall = 1'b1;
    wr(O_CMD, 32'h0108_00F0);
    chk("R4 read req", {30'b0, sub_req, sub_we}, 2);
    stall = 1'b0;
    wait_idle();
    rd(O_LD, v); chk("R5 lane3", v, {mem[8'hF0], 24'b0});

    // R4 data store with direction 1 starts nothing
    wr(O_LD, 32'h0000_0055);
    chk("R4 no start", {31'b0, sub_req}, 0);
    rd(O_LD, v); chk("R4 ldata kept", v, 32'h55);

    // R6 acknowledge while idle
    wr(O_IFL, 3);
    @(posedge clk); #1 idle_ack = 1'b1;
    @(posedge clk); #1 idle_ack = 1'b0;
    @(negedge clk);
    rd(O_CMD, v); chk("R6 idle ack busy", {31'b0, v[31]}, 0);
    rd(O_IFL, v); chk("R6 idle ack flags", v, 0);
    rd(O_LD, v);  chk("R6 idle ack ldata", v, 32'h55);

    // R9 subsystem interrupt, set wins over clear
    @(negedge clk); sub_irq = 1'b1;
    repeat (2) @(negedge clk);
    rd(O_IFL, v); chk("R9 sub flag", v, 2);
    wr(O_IFL, 2);
    rd(O_IFL, v); chk("R9 set wins", v, 2);
    wr(O_IEN, 2);
    chk("R10 sub irq", {31'b0, irq_o}, 1);
    sub_irq = 1'b0;
    wr(O_IFL, 2);
    rd(O_IFL, v); chk("R9 sub cleared", v, 0);
    chk("R10 sub irq off", {31'b0, irq_o}, 0);
    wr(O_IEN, 0);

    // random transfers in both directions
    for (int it = 0; it < 150; it++) begin
      a = 8'($urandom); d = $urandom; en = 4'($urandom);
      wr(O_CMD, {8'h00, 4'($urandom), en, 8'h00, a});
      wr(O_LD, d);
      wait_idle();
      chk("R3 random write", {24'b0, mem[a]}, {24'b0, d[lane_of(en)*8 +: 8]});
      en = 4'($urandom);
      wr(O_CMD, {7'h00, 1'b1, 4'h0, en, 8'h00, a});
      wait_idle();
      rd(O_LD, v);
      chk("R5 random read", v, {24'b0, mem[a]} << (lane_of(en) * 8));
    end

    summary();
  end
endmodule